// File: doc/BRIEF.md
# Dual-Start Burst Address Generator

This block produces the word address that a synchronous burst memory presents to its array on every clock cycle. A burst may be opened by either of two start strobes. One is driven from the processor side and is honoured only while the primary chip enable is active. The other is driven from the memory controller side and is always honoured. Either strobe captures the external address as the burst base and clears an internal burst counter. While the advance input is high, the counter then steps the low address bits on each rising clock edge. The upper address bits stay at their loaded value.

The order input is sampled at run time and selects how the counter maps onto the low address bits. In linear order, the low bits are the loaded low bits plus the count, wrapping inside the burst. In interleaved order, they are the loaded low bits XOR the count. With the default counter width of 2, a burst covers four words. Bursting is optional: a new external address may be loaded on any cycle. All strobe, enable and advance inputs are sampled on the rising clock edge. The output address comes from registered state, so it changes one cycle after the controlling edge.

Top module: `burst_addr_gen`

## Requirements
- R1: After reset, `word_addr` is all zeros.
- R2: On a rising edge with a load, the whole `addr_in` becomes `word_addr` in the following cycle. A load is `start_ctl` high, or `start_cpu` high together with `ce_pri` high. The burst count restarts at zero.
- R3: On an edge with no load, `adv` high steps the burst count by one and `adv` low holds it, so `word_addr` stays unchanged.
- R4: When a load and `adv` share an edge, the load wins: the next `word_addr` equals `addr_in` with count zero.
- R5: With `order_il` low (linear), the low 2 bits of `word_addr` equal (loaded low bits + count) mod 4.
- R6: With `order_il` high (interleaved), the low 2 bits of `word_addr` equal the loaded low bits XOR count.
- R7: The upper bits `word_addr[ADDR_W-1:2]` stay at their loaded value between loads. After four advances the count wraps to zero, so the start address returns, and stepping continues while `adv` stays high.
- R8: `start_cpu` has no effect while `ce_pri` is low. `start_ctl` loads whatever the level of `ce_pri`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr_in | input | ADDR_W | External address captured on a load |
| start_cpu | input | 1 | Processor-side burst start, gated by `ce_pri` |
| start_ctl | input | 1 | Controller-side burst start, ungated |
| ce_pri | input | 1 | Primary chip enable, qualifies `start_cpu` |
| adv | input | 1 | Step the burst counter when no load occurs |
| order_il | input | 1 | 0 = linear order, 1 = interleaved order |
| word_addr | output | ADDR_W | Address presented to the array |

## Verification
The embedded properties check these rules on every cycle:
- A load clears the count and places `addr_in` on the output in the next cycle.
- Without a load, `adv` either steps the count by exactly one or leaves it stable.
- The upper bits never move without a load.
- A gated processor strobe leaves the upper bits untouched.

The bench scenarios cover what the properties cannot show:
- The actual linear and interleaved sequences from each of the four start offsets.
- Wrap-around after four words.
- A load winning over an advance on the same edge.
- The difference between a gated processor strobe and an ungated controller strobe.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;
  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } burst_order_e;

  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,
    ACT_STEP = 2'd1,
    ACT_LOAD = 2'd2
  } cnt_action_e;
endpackage

// File: rtl/bag_reset_sync.sv
module bag_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_s = chain_q[STAGES-1];
endmodule

// File: rtl/bag_load_ctl.sv
module bag_load_ctl
  import burst_addr_pkg::*;
(
  input  logic        start_cpu,
  input  logic        start_ctl,
  input  logic        ce_pri,
  input  logic        adv,
  output logic        load,
  output cnt_action_e action
);
  logic cpu_ok;

  always_comb begin
    cpu_ok = start_cpu & ce_pri;
    load   = start_ctl | cpu_ok;
    if (load)     action = ACT_LOAD;
    else if (adv) action = ACT_STEP;
    else          action = ACT_HOLD;
  end
endmodule

// File: rtl/bag_burst_state.sv
module bag_burst_state
  import burst_addr_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int CNT_W  = 2
) (
  input  logic              clk,
  input  logic              rst_s,
  input  cnt_action_e       action,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] base_q,
  output logic [CNT_W-1:0]  cnt_q
);
  logic [ADDR_W-1:0] base_d;
  logic [CNT_W-1:0]  cnt_d;
  logic              base_en;
  logic              cnt_en;

  always_comb begin
    base_en = (action == ACT_LOAD);
    cnt_en  = (action != ACT_HOLD);
    base_d  = addr_in;
    cnt_d   = (action == ACT_LOAD) ? '0 : cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s)       base_q <= '0;
    else if (base_en) base_q <= base_d;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  AST_LOAD_CLEARS: assert property (@(posedge clk) disable iff (!rst_s)
    (action == ACT_LOAD) |=> (cnt_q == '0)) else $error("load did not clear count"); // R2
  AST_ADV_STEPS: assert property (@(posedge clk) disable iff (!rst_s)
    (action == ACT_STEP) |=> (cnt_q == $past(cnt_q) + CNT_W'(1))) else $error("advance did not step"); // R3
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_s)
    (action == ACT_HOLD) |=> $stable(cnt_q)) else $error("count moved while idle"); // R3
endmodule

// File: rtl/bag_order_map.sv
module bag_order_map
  import burst_addr_pkg::*;
#(
  parameter int CNT_W = 2
) (
  input  burst_order_e     order,
  input  logic [CNT_W-1:0] base_lo,
  input  logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] lo_out
);
  logic [CNT_W-1:0] lin_lo;
  logic [CNT_W-1:0] il_lo;

  always_comb lin_lo = base_lo + cnt;

  for (genvar b = 0; b < CNT_W; b++) begin : g_il_bit
    assign il_lo[b] = base_lo[b] ^ cnt[b];
  end

  always_comb lo_out = (order == ORD_INTERLEAVE) ? il_lo : lin_lo;
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_addr_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int CNT_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              start_cpu,
  input  logic              start_ctl,
  input  logic              ce_pri,
  input  logic              adv,
  input  logic              order_il,
  output logic [ADDR_W-1:0] word_addr
);
  localparam int HI_W = ADDR_W - CNT_W;

  logic              rst_s;
  logic              load;
  cnt_action_e       action;
  logic [ADDR_W-1:0] base_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  lo_bits;
  burst_order_e      order;

  assign order = order_il ? ORD_INTERLEAVE : ORD_LINEAR;

  bag_reset_sync #(.STAGES(2)) u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .rst_s (rst_s)
  );

  bag_load_ctl u_ctl (
    .start_cpu (start_cpu),
    .start_ctl (start_ctl),
    .ce_pri    (ce_pri),
    .adv       (adv),
    .load      (load),
    .action    (action)
  );

  bag_burst_state #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_state (
    .clk     (clk),
    .rst_s   (rst_s),
    .action  (action),
    .addr_in (addr_in),
    .base_q  (base_q),
    .cnt_q   (cnt_q)
  );

  bag_order_map #(.CNT_W(CNT_W)) u_map (
    .order   (order),
    .base_lo (base_q[CNT_W-1:0]),
    .cnt     (cnt_q),
    .lo_out  (lo_bits)
  );

  assign word_addr = {base_q[ADDR_W-1:CNT_W], lo_bits};

  AST_LOAD_TAKES_ADDR: assert property (@(posedge clk) disable iff (!rst_s)
    (load && $stable(order_il)) |=> (word_addr == $past(addr_in))) else $error("load address lost"); // R2
  AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (!rst_s)
    !load |=> $stable(word_addr[ADDR_W-1:CNT_W])) else $error("upper bits moved"); // R7
  AST_CPU_GATED: assert property (@(posedge clk) disable iff (!rst_s)
    (start_cpu && !ce_pri && !start_ctl) |=> $stable(word_addr[ADDR_W-1:HI_W-HI_W+CNT_W])) else $error("gated strobe loaded"); // R8
endmodule

// File: tb/tb_burst_addr_gen.sv
module tb_burst_addr_gen;
  localparam int AW = 20;

  typedef struct {
    logic [AW-1:0] addr;
    string         req;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] addr_in;
  logic          start_cpu, start_ctl, ce_pri, adv, order_il;
  logic [AW-1:0] word_addr;

  int   n_checks = 0;
  int   n_fail   = 0;
  exp_t q[$];

  logic [AW-1:0] m_base;
  logic [1:0]    m_cnt;
  bit            done = 0;

  burst_addr_gen #(.ADDR_W(AW), .CNT_W(2)) dut (
    .clk(clk), .rst_n(rst_n), .addr_in(addr_in), .start_cpu(start_cpu),
    .start_ctl(start_ctl), .ce_pri(ce_pri), .adv(adv), .order_il(order_il),
    .word_addr(word_addr)
  );

  always #2 clk = ~clk;

  function automatic logic [AW-1:0] model_addr(input logic il);
    logic [1:0] lo;
    lo = il ? (m_base[1:0] ^ m_cnt) : (m_base[1:0] + m_cnt);
    return {m_base[AW-1:2], lo};
  endfunction

  task automatic check(input logic [AW-1:0] act, input logic [AW-1:0] exp, input string req);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: word_addr actual %h expected %h", req, act, exp);
    end
  endtask

  // Driver: one clock cycle of stimulus, model update, expected value queued.
  task automatic cycle(input logic cpu, input logic ctl, input logic ce, input logic a,
                       input logic il, input logic [AW-1:0] ad, input string req);
    exp_t e;
    @(negedge clk);
    #1;
    start_cpu = cpu; start_ctl = ctl; ce_pri = ce; adv = a; order_il = il; addr_in = ad;
    @(posedge clk);
    if (ctl || (cpu && ce)) begin
      m_base = ad;
      m_cnt  = 2'd0;
    end else if (a) begin
      m_cnt = m_cnt + 2'd1;
    end
    #1;
    e.addr = model_addr(il);
    e.req  = req;
    q.push_back(e);
  endtask

  // Monitor: pops one expected item per cycle, away from the active edge.
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        check(word_addr, e.addr, e.req);
      end
    end
  end

  initial begin
    #(4 * 20000);
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    start_cpu = 0; start_ctl = 0; ce_pri = 0; adv = 0; order_il = 0; addr_in = '0;
    m_base = '0; m_cnt = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(word_addr, '0, "R1");

    // Both orders, every start offset, loaded from the processor strobe.
    for (int il = 0; il < 2; il++) begin
      for (int off = 0; off < 4; off++) begin
        logic [AW-1:0] a0;
        string rq;
        rq = il ? "R6" : "R5";
        a0 = {18'h2A5C0 + 18'(off * 3 + il), 2'(off)};
        cycle(1, 0, 1, 0, il[0], a0, "R2");
        cycle(0, 0, 1, 1, il[0], '1, rq);
        cycle(0, 0, 1, 0, il[0], '1, "R3");
        cycle(0, 0, 1, 1, il[0], '0, rq);
        cycle(0, 0, 1, 1, il[0], '0, rq);
        cycle(0, 0, 1, 1, il[0], '0, "R7");
        cycle(0, 0, 1, 1, il[0], '0, "R7");
      end
    end

    // Controller strobe with chip enable low still loads.
    cycle(0, 1, 0, 0, 0, 20'h12343, "R8");
    cycle(0, 0, 0, 1, 0, 20'h0, "R5");
    // Processor strobe with chip enable low is ignored; state continues.
    cycle(1, 0, 0, 0, 0, 20'hFFFF0, "R8");
    cycle(1, 0, 0, 1, 1, 20'hABCD2, "R8");
    // Load and advance on the same edge: load wins.
    cycle(1, 0, 1, 1, 1, 20'h55556, "R4");
    cycle(0, 1, 0, 1, 0, 20'h0F0F1, "R4");
    cycle(0, 0, 1, 1, 0, 20'h0, "R5");
    // Back-to-back loads without bursting.
    cycle(0, 1, 1, 0, 1, 20'h00003, "R2");
    cycle(1, 0, 1, 0, 1, 20'hFFFFF, "R2");
    cycle(0, 0, 1, 1, 1, 20'h0, "R6");
    cycle(0, 0, 1, 0, 1, 20'h0, "R3");

    @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule